// File: doc/BRIEF.md
# Link Status Change Interrupt Controller

This block gathers eight status conditions of a 10/100 Ethernet transceiver (energy on the line, auto-negotiation done, remote fault, link loss, link-partner acknowledge, parallel-detect fault, page received and a wake indication) and turns selected transitions of each into a sticky flag. A host-visible enable register selects which flags may pull the active-low interrupt pin. Each flag has its own set edge and its own list of clearing events, so a host service routine can clear a flag by reading the register that reports the cause, by reading the flag register, or simply by the condition going away.

The host side is a plain register port: address, read strobe, write strobe, write data and a read-data bus. The block watches this port so that reads of the flag register, the basic status register and the negotiation expansion register act as clear events. Status inputs are taken to be synchronous to the block clock; only the primary interrupt mode is built.

Top module: `link_irq_ctrl`

## Requirements
- R1: During and straight after reset the interrupt pin is high, the enable register reads 0 and every flag reads 0 except the energy flag, which reads 1.
- R2: The flag register (address 29) and enable register (address 30) place the sources in bits 8..1: bit 8 wake, bit 7 energy, bit 6 negotiation done, bit 5 remote fault, bit 4 link down, bit 3 partner acknowledge, bit 2 parallel-detect fault, bit 1 page received; all other bits and all other addresses read 0.
- R3: A rising edge of energy, negotiation done, remote fault, partner acknowledge, parallel-detect fault or page received sets its flag; a falling edge of link status sets the link-down flag; a rising edge of the OR of the three wake bits sets the wake flag.
- R4: The interrupt pin is registered: it is low from the clock edge at which a flag with its enable bit at 1 becomes set, and high whenever no enabled flag is set; disabled flags still read back.
- R5: A read strobe at address 29 returns the flags as they stood before the read and clears all flags at that clock edge.
- R6: A falling edge of energy, negotiation done, remote fault, partner acknowledge, parallel-detect fault or page received clears its own flag.
- R7: A read strobe at address 1 clears the remote-fault and link-down flags and no other flag.
- R8: A read strobe at address 6, a negotiation restart pulse, or a falling edge of link status clears the parallel-detect-fault and page-received flags.
- R9: The wake flag clears in any cycle in which the active-low power-management-event input is low.
- R10: When a set event and a clear event of one flag fall in the same cycle, the flag ends up set.
- R11: A write strobe at address 30 loads bits 8..1 of the write data into the enable register; writes to address 29 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| energy_det | input | 1 | Energy present on the line |
| aneg_done | input | 1 | Auto-negotiation complete |
| remote_fault | input | 1 | Remote fault reported by partner |
| link_up | input | 1 | Link status |
| partner_ack | input | 1 | Link-partner acknowledge seen |
| pdet_fault | input | 1 | Parallel-detection fault |
| page_rcvd | input | 1 | Negotiation page received |
| wake_stat | input | 3 | Wake status bits, ORed into one source |
| pme_n | input | 1 | Active-low power-management-event level |
| aneg_restart | input | 1 | One-cycle pulse: negotiation restarted |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status edge, read strobe or write presented before a clock edge shows up in the flags, the enable register and the interrupt pin right after that one edge, because the edge detector, flags, enable and interrupt register all update together from the same next values. The bench drives inputs at the falling clock edge, lets one rising edge pass and samples at the next falling edge; read data is combinational, so the pre-clear value of a read is sampled one time unit after the strobe is driven and before the edge. The interrupt pin is also sampled before the edge to confirm it does not move early.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
    localparam int NSRC = 8;

    // Source index inside the flag vector (bit i sits at register bit i+1)
    localparam int SRC_PGRX   = 0;
    localparam int SRC_PDF    = 1;
    localparam int SRC_ACK    = 2;
    localparam int SRC_LINKDN = 3;
    localparam int SRC_RFLT   = 4;
    localparam int SRC_ANDONE = 5;
    localparam int SRC_ENERGY = 6;
    localparam int SRC_WAKE   = 7;

    // Energy status is taken as high when acquisition starts
    localparam logic [NSRC-1:0] SRC_RST = NSRC'(1) << SRC_ENERGY;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            irq_n;
    } ctl_t;
endpackage

// File: rtl/link_irq_edge.sv
module link_irq_edge #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
        fall   = ~sig & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/link_irq_flags.sv
module link_irq_flags #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] clr_ev,
    output logic [W-1:0] flag_d,
    output logic [W-1:0] flag_q
);
    // Per bit: a set in the same cycle as a clear keeps the flag
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            flag_d[i] = set_ev[i] | (flag_q[i] & ~clr_ev[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl
    import link_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int FLAG_ADDR = 29,
    parameter int MASK_ADDR = 30,
    parameter int STAT_ADDR = 1,
    parameter int EXP_ADDR  = 6,
    parameter int FIELD_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              energy_det,
    input  logic              aneg_done,
    input  logic              remote_fault,
    input  logic              link_up,
    input  logic              partner_ack,
    input  logic              pdet_fault,
    input  logic              page_rcvd,
    input  logic [2:0]        wake_stat,
    input  logic              pme_n,
    input  logic              aneg_restart,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    localparam int FIELD_MSB = FIELD_LSB + NSRC - 1;

    logic [NSRC-1:0] status, rise, fall;
    logic [NSRC-1:0] set_ev, clr_ev;
    logic [NSRC-1:0] flag_d, flag_q;
    logic [NSRC-1:0] mask_q;
    logic            rd_flag, rd_stat, rd_exp, wr_mask;
    logic            wdata_unused;
    ctl_t            ctl_d, ctl_q;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        status             = '0;
        status[SRC_PGRX]   = page_rcvd;
        status[SRC_PDF]    = pdet_fault;
        status[SRC_ACK]    = partner_ack;
        status[SRC_LINKDN] = link_up;
        status[SRC_RFLT]   = remote_fault;
        status[SRC_ANDONE] = aneg_done;
        status[SRC_ENERGY] = energy_det;
        status[SRC_WAKE]   = |wake_stat;
    end

    link_irq_edge #(.W(NSRC), .RST_VAL(SRC_RST)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (status),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        rd_flag = reg_rd && (reg_addr == ADDR_W'(FLAG_ADDR));
        rd_stat = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));
        rd_exp  = reg_rd && (reg_addr == ADDR_W'(EXP_ADDR));
        wr_mask = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));

        // Set events: rising edges, except link status which sets on its fall
        set_ev             = rise;
        set_ev[SRC_LINKDN] = fall[SRC_LINKDN];

        // Clear events: each source has its own list; flag read clears all
        clr_ev             = {NSRC{rd_flag}};
        clr_ev[SRC_PGRX]   = clr_ev[SRC_PGRX] | fall[SRC_PGRX] | rd_exp
                           | aneg_restart | fall[SRC_LINKDN];
        clr_ev[SRC_PDF]    = clr_ev[SRC_PDF] | fall[SRC_PDF] | rd_exp
                           | aneg_restart | fall[SRC_LINKDN];
        clr_ev[SRC_ACK]    = clr_ev[SRC_ACK] | fall[SRC_ACK];
        clr_ev[SRC_LINKDN] = clr_ev[SRC_LINKDN] | rd_stat;
        clr_ev[SRC_RFLT]   = clr_ev[SRC_RFLT] | fall[SRC_RFLT] | rd_stat;
        clr_ev[SRC_ANDONE] = clr_ev[SRC_ANDONE] | fall[SRC_ANDONE];
        clr_ev[SRC_ENERGY] = clr_ev[SRC_ENERGY] | fall[SRC_ENERGY];
        clr_ev[SRC_WAKE]   = clr_ev[SRC_WAKE] | ~pme_n;
    end

    link_irq_flags #(.W(NSRC), .RST_VAL(SRC_RST)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(set_ev),
        .clr_ev(clr_ev),
        .flag_d(flag_d),
        .flag_q(flag_q)
    );

    // Enable register and registered interrupt pin
    always_comb begin
        ctl_d = ctl_q;
        if (wr_mask) ctl_d.mask = reg_wdata[FIELD_MSB:FIELD_LSB];
        ctl_d.irq_n = ~|(flag_d & ctl_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mask  <= '0;
            ctl_q.irq_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mask_q = ctl_q.mask;
    assign irq_n  = ctl_q.irq_n;

    // Read data reflects state before any clear caused by this read
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(FLAG_ADDR))
            reg_rdata[FIELD_MSB:FIELD_LSB] = flag_q;
        else if (reg_addr == ADDR_W'(MASK_ADDR))
            reg_rdata[FIELD_MSB:FIELD_LSB] = mask_q;
    end
endmodule

// File: rtl/link_irq_chk.sv
module link_irq_chk
    import link_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int FLAG_ADDR = 29,
    parameter int MASK_ADDR = 30,
    parameter int FIELD_LSB = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              pme_n,
    input logic [NSRC-1:0]   set_ev,
    input logic [NSRC-1:0]   flag_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq_n
);
    localparam int FIELD_MSB = FIELD_LSB + NSRC - 1;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((flag_q & $past(set_ev)) == $past(set_ev))); // R10

    AST_FLAGREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(FLAG_ADDR) && set_ev == '0) |=> (flag_q == '0)); // R5

    AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == ~|(flag_q & mask_q))); // R4

    AST_PME_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_n && !set_ev[SRC_WAKE]) |=> !flag_q[SRC_WAKE]); // R9

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(MASK_ADDR)) |=>
        (mask_q == $past(reg_wdata[FIELD_MSB:FIELD_LSB]))); // R11
endmodule

bind link_irq_ctrl link_irq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR),
    .MASK_ADDR(MASK_ADDR), .FIELD_LSB(FIELD_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .pme_n    (pme_n),
    .set_ev   (set_ev),
    .flag_q   (flag_q),
    .mask_q   (mask_q),
    .irq_n    (irq_n)
);

// File: tb/sim_link_irq_ctrl.sv
module sim_link_irq_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        energy_det, aneg_done, remote_fault, link_up;
    logic        partner_ack, pdet_fault, page_rcvd;
    logic [2:0]  wake_stat;
    logic        pme_n, aneg_restart;
    logic [4:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    link_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .energy_det(energy_det), .aneg_done(aneg_done),
        .remote_fault(remote_fault), .link_up(link_up), .partner_ack(partner_ack),
        .pdet_fault(pdet_fault), .page_rcvd(page_rcvd), .wake_stat(wake_stat),
        .pme_n(pme_n), .aneg_restart(aneg_restart), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // st: [6] energy [5] neg done [4] remote fault [3] link [2] ack [1] pdf [0] page
    // ef: expected flags, index order of register bits 8..1
    typedef struct packed {
        logic [6:0] st;
        logic [2:0] wk;
        logic       pme;
        logic       rs;
        logic       rd;
        logic       wr;
        logic [4:0] ad;
        logic [7:0] wd;
        logic [7:0] ef;
        logic       ei;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{7'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 1'b1}, // R6 energy falls
        '{7'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd30, 8'hFF, 8'h00, 1'b1}, // R11 enable all
        '{7'h28, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h20, 1'b0}, // R3 neg done
        '{7'h28, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd1,  8'h00, 8'h20, 1'b0}, // R7 no effect
        '{7'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 1'b1}, // R6
        '{7'h18, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h10, 1'b0}, // R3 rflt
        '{7'h18, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd1,  8'h00, 8'h00, 1'b1}, // R7
        '{7'h1B, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h03, 1'b0}, // R3 pdf page
        '{7'h1B, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd6,  8'h00, 8'h00, 1'b1}, // R8 read 6
        '{7'h18, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 1'b1},
        '{7'h1B, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h03, 1'b0},
        '{7'h1B, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 1'b1}, // R8 restart
        '{7'h18, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h00, 1'b1},
        '{7'h1B, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h03, 1'b0},
        '{7'h13, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h08, 1'b0}, // R3 R8 link loss
        '{7'h13, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd29, 8'h00, 8'h00, 1'b1}, // R5
        '{7'h17, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h04, 1'b0}, // R3 ack
        '{7'h17, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h84, 1'b0}, // R3 wake
        '{7'h17, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h04, 1'b0}, // R9
        '{7'h17, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 5'd30, 8'hFB, 8'h04, 1'b1}, // R4 masked
        '{7'h57, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h00, 8'h44, 1'b0}, // R3 energy
        '{7'h57, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 5'd29, 8'h00, 8'h44, 1'b0}  // R11 write 29
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic idle_port();
        aneg_restart = 1'b0;
        reg_rd       = 1'b0;
        reg_wr       = 1'b0;
        reg_wdata    = '0;
        reg_addr     = 5'd0;
    endtask

    task automatic apply(input vec_t v);
        {energy_det, aneg_done, remote_fault, link_up,
         partner_ack, pdet_fault, page_rcvd} = v.st;
        wake_stat    = v.wk;
        pme_n        = v.pme;
        aneg_restart = v.rs;
        reg_rd       = v.rd;
        reg_wr       = v.wr;
        reg_addr     = v.ad;
        reg_wdata    = {7'd0, v.wd, 1'b0};
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [4:0] a, input string req, input logic [15:0] exp);
        reg_addr = a;
        reg_rd   = 1'b0;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        {energy_det, aneg_done, remote_fault, link_up,
         partner_ack, pdet_fault, page_rcvd} = '0;
        wake_stat = '0;
        pme_n     = 1'b1;
        idle_port();
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {15'd0, irq_n}, 16'h0001);
        rst_n = 1'b1;
        peek(5'd29, "R1 flags after reset", 16'h0080);
        peek(5'd30, "R1 enable after reset", 16'h0000);
        chk("R1 irq after reset", {15'd0, irq_n}, 16'h0001);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            step();
            idle_port();
            chk($sformatf("R4 irq row %0d", i), {15'd0, irq_n}, {15'd0, TBL[i].ei});
            peek(5'd29, $sformatf("R2 flags row %0d", i), {7'd0, TBL[i].ef, 1'b0});
        end

        // R5: read returns pre-clear value, then flags are gone
        @(negedge clk);
        reg_addr = 5'd29;
        reg_rd   = 1'b1;
        #1;
        chk("R5 pre-clear read", reg_rdata, 16'h0088);
        step();
        idle_port();
        peek(5'd29, "R5 cleared", 16'h0000);
        chk("R4 irq after clear", {15'd0, irq_n}, 16'h0001);

        // R10: negotiation done rises in the same cycle as a flag read
        aneg_done = 1'b1;
        reg_addr  = 5'd29;
        reg_rd    = 1'b1;
        #1;
        chk("R4 irq not before edge", {15'd0, irq_n}, 16'h0001);
        step();
        idle_port();
        peek(5'd29, "R10 set wins", 16'h0040);
        chk("R4 irq after set", {15'd0, irq_n}, 16'h0000);

        // R2: other addresses and enable read-back
        peek(5'd1, "R2 other address", 16'h0000);
        peek(5'd30, "R2 enable field", 16'h01F6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule